// File: doc/BRIEF.md
# Seed Extension Alignment Array

This block scores the extension of an exact-match seed against a stretch of reference sequence. Before a job starts, the query symbols are written one by one into a linear chain of processing elements, one symbol per element. A start pulse then fixes the job parameters: the query length, the seed score, and the match reward, mismatch penalty and gap penalty.

After the start pulse, the reference symbols stream in, one per accepted cycle. Each reference symbol produces one row of the similarity matrix. The row sweeps down the chain one element per cycle, so the cells of one anti-diagonal are computed together. No cell is skipped.

The matrix origin holds the seed score. The first row and first column fall by the gap penalty for each step away from the origin, and they never go below zero. Once the last reference symbol has passed the element that holds the final query symbol, the tail stage issues one result record. The record holds:
- the best score anywhere in the matrix, with its row and column;
- the best score in the last query column, with its row;
- the largest distance from the diagonal seen when the best score improved.

Top module: `seed_ext_array`

## Requirements
- R1: After reset, `res_valid` is low and stays low until a job's last reference symbol has been processed.
- R2: Each cell equals the largest of: zero; the upper-left cell plus the match reward (equal symbols) or minus the mismatch penalty (unequal symbols); the upper cell minus the gap penalty; and the left cell minus the gap penalty. The penalties are unsigned magnitudes sampled at `ext_start`, and `res_local` reports the largest cell of the job.
- R3: Cell (0,0) holds the seed score. Boundary cell (0,k) and boundary cell (k,0) hold max(seed − k·gap, 0). With no improving cell, the local result is the seed score at row 0, column 0.
- R4: Rows are numbered from 1 in arrival order, and columns from 1 at the element holding query address 0. Inside one row, the leftmost cell holding the row maximum represents the row. The local best moves only when a row's maximum is strictly greater than the best so far.
- R5: `res_global` is the largest cell in column `ext_qlen`, with the earliest row that reaches it. The starting value is boundary cell (0, `ext_qlen`) at row 0.
- R6: `res_max_off` is the largest |row − column| over the moves of the local best. It is 0 when the local best never moves.
- R7: Any query length from 1 to NPE is served. The exit point is the element at column `ext_qlen`, and no column beyond it affects the result.
- R8: `res_valid` is raised for exactly one cycle. It appears `ext_qlen`+1 rising edges after the edge that accepts the reference symbol flagged `ref_last`.
- R9: Idle cycles (`ref_valid` low) between reference symbols do not change the result.
- R10: Cell scores saturate at 32767, including when the seed score is at that limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| q_we | input | 1 | Write one query symbol |
| q_addr | input | 8 | Query position written (0-based) |
| q_sym | input | 2 | Query symbol |
| ext_start | input | 1 | Start a job; samples the fields below |
| ext_qlen | input | 8 | Query length, 1 to NPE |
| ext_seed | input | 15 | Seed score |
| cfg_match | input | 8 | Match reward |
| cfg_mismatch | input | 8 | Mismatch penalty magnitude |
| cfg_gap | input | 8 | Gap penalty magnitude |
| ref_valid | input | 1 | Reference symbol present |
| ref_sym | input | 2 | Reference symbol |
| ref_last | input | 1 | Marks the job's final reference symbol |
| res_valid | output | 1 | Result record valid (one cycle) |
| res_local | output | 16 | Best score in the matrix |
| res_local_row | output | 16 | Row of the best score |
| res_local_col | output | 8 | Column of the best score |
| res_global | output | 16 | Best score in the last query column |
| res_global_row | output | 16 | Row of that score |
| res_max_off | output | 16 | Largest diagonal distance of a best-score move |

## Verification
In the tail stage, the local-best update and the global-best update can happen in the same cycle. This occurs when a row's maximum sits in the last query column.

Directed jobs whose reference equals the query provoke this. In such a job the diagonal climbs into the last column on the final row, so both updates fire on that row. Random jobs with short queries provoke it often.

The bench judges each job by comparing all six result fields with its own dynamic-programming model. The model applies the same tie rules, so both updates must carry the same row for the job to pass.

// File: rtl/seed_ext_pkg.sv
package seed_ext_pkg;
  localparam int SCORE_W   = 16;
  localparam int SCORE_MAX = 32767;

  typedef logic [SCORE_W-1:0] score_t;

  // subtract and floor at zero
  function automatic int floor_sub(input int a, input int b);
    int d;
    d = a - b;
    return (d < 0) ? 0 : d;
  endfunction

  // one similarity cell with zero floor and upper saturation
  function automatic int cell_best(input int diag, input int up, input int left,
                                   input bit hit, input int ma, input int mm,
                                   input int g);
    int h;
    int d;
    h = 0;
    d = diag + (hit ? ma : -mm);
    if (d > h) h = d;
    if (up - g > h) h = up - g;
    if (left - g > h) h = left - g;
    if (h > SCORE_MAX) h = SCORE_MAX;
    return h;
  endfunction

  // distance between row and column
  function automatic int diag_dist(input int row, input int col);
    return (row > col) ? row - col : col - row;
  endfunction
endpackage

// File: rtl/seed_ext_head.sv
module seed_ext_head
  import seed_ext_pkg::*;
#(
  parameter int SYM_W = 2,
  parameter int PEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  score_t           seed,
  input  logic [PEN_W-1:0] gap,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_sym,
  input  logic             in_last,
  output logic             out_valid,
  output logic             out_first,
  output logic             out_last,
  output logic [SYM_W-1:0] out_sym,
  output score_t           out_score,
  output score_t           out_bnd
);
  score_t lft;
  score_t seed_r;
  logic   pend_first;
  score_t nxt_left;

  assign nxt_left = score_t'(floor_sub(int'(lft), int'(gap)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lft        <= '0;
      seed_r     <= '0;
      pend_first <= 1'b0;
      out_valid  <= 1'b0;
      out_first  <= 1'b0;
      out_last   <= 1'b0;
      out_sym    <= '0;
      out_score  <= '0;
      out_bnd    <= '0;
    end else begin
      out_valid <= in_valid && !start;
      if (start) begin
        lft        <= seed;
        seed_r     <= seed;
        pend_first <= 1'b1;
      end else if (in_valid) begin
        lft        <= nxt_left;
        pend_first <= 1'b0;
        out_first  <= pend_first;
        out_last   <= in_last;
        out_sym    <= in_sym;
        out_score  <= nxt_left;
        out_bnd    <= seed_r;
      end
    end
  end

  // R3: the first row leaving the head carries the seed as its corner value
  assert_corner_is_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_first |-> out_bnd == seed_r);
endmodule

// File: rtl/seed_ext_pe.sv
module seed_ext_pe
  import seed_ext_pkg::*;
#(
  parameter int SYM_W = 2,
  parameter int PEN_W = 8,
  parameter int IDX_W = 8,
  parameter int COL   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_we,
  input  logic [IDX_W-1:0] q_addr,
  input  logic [SYM_W-1:0] q_sym,
  input  logic [PEN_W-1:0] ma,
  input  logic [PEN_W-1:0] mm,
  input  logic [PEN_W-1:0] gap,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_last,
  input  logic [SYM_W-1:0] in_sym,
  input  score_t           in_score,
  input  score_t           in_bnd,
  input  score_t           in_rmax,
  input  logic [IDX_W-1:0] in_ridx,
  output logic             out_valid,
  output logic             out_first,
  output logic             out_last,
  output logic [SYM_W-1:0] out_sym,
  output score_t           out_score,
  output score_t           out_bnd,
  output score_t           out_rmax,
  output logic [IDX_W-1:0] out_ridx
);
  localparam logic [IDX_W-1:0] MY_ADDR = IDX_W'(COL - 1);
  localparam logic [IDX_W-1:0] MY_COL  = IDX_W'(COL);

  logic [SYM_W-1:0] qsym;
  score_t prev_left;
  score_t prev_h;
  score_t up_bnd;
  score_t diag_v;
  score_t up_v;
  score_t cell_h;
  logic   sym_hit;
  logic   row_take;

  assign up_bnd   = score_t'(floor_sub(int'(in_bnd), int'(gap)));
  assign diag_v   = in_first ? in_bnd : prev_left;
  assign up_v     = in_first ? up_bnd : prev_h;
  assign sym_hit  = (qsym == in_sym);
  assign cell_h   = score_t'(cell_best(int'(diag_v), int'(up_v), int'(in_score),
                                       sym_hit, int'(ma), int'(mm), int'(gap)));
  assign row_take = cell_h > in_rmax;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qsym      <= '0;
      prev_left <= '0;
      prev_h    <= '0;
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      out_sym   <= '0;
      out_score <= '0;
      out_bnd   <= '0;
      out_rmax  <= '0;
      out_ridx  <= '0;
    end else begin
      if (q_we && q_addr == MY_ADDR) qsym <= q_sym;
      out_valid <= in_valid;
      if (in_valid) begin
        prev_left <= in_score;
        prev_h    <= cell_h;
        out_first <= in_first;
        out_last  <= in_last;
        out_sym   <= in_sym;
        out_score <= cell_h;
        out_bnd   <= up_bnd;
        out_rmax  <= row_take ? cell_h : in_rmax;
        out_ridx  <= row_take ? MY_COL : in_ridx;
      end
    end
  end

  // R4: the row maximum leaving an element covers that element's own cell
  assert_rowmax_covers_cell_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_rmax >= out_score);
  // R10: cells never exceed the saturation limit
  assert_cell_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_score) <= SCORE_MAX);
endmodule

// File: rtl/seed_ext_tail.sv
module seed_ext_tail
  import seed_ext_pkg::*;
#(
  parameter int PEN_W = 8,
  parameter int IDX_W = 8,
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  score_t           seed,
  input  logic [IDX_W-1:0] qlen,
  input  logic [PEN_W-1:0] gap,
  input  logic             in_valid,
  input  logic             in_last,
  input  score_t           in_score,
  input  score_t           in_rmax,
  input  logic [IDX_W-1:0] in_ridx,
  output logic             res_valid,
  output score_t           res_local,
  output logic [ROW_W-1:0] res_local_row,
  output logic [IDX_W-1:0] res_local_col,
  output score_t           res_global,
  output logic [ROW_W-1:0] res_global_row,
  output logic [ROW_W-1:0] res_max_off
);
  logic [ROW_W-1:0] row;
  score_t           best;
  logic [ROW_W-1:0] brow;
  logic [IDX_W-1:0] bcol;
  logic [ROW_W-1:0] off;
  score_t           gbest;
  logic [ROW_W-1:0] grow;
  logic [IDX_W-1:0] qlen_r;

  logic [ROW_W-1:0] row_n;
  logic             local_move;
  logic             global_move;
  logic [ROW_W-1:0] move_dist;
  score_t           n_best;
  logic [ROW_W-1:0] n_brow;
  logic [IDX_W-1:0] n_bcol;
  logic [ROW_W-1:0] n_off;
  score_t           n_gbest;
  logic [ROW_W-1:0] n_grow;

  always_comb begin
    row_n       = row + 1'b1;
    local_move  = in_rmax > best;
    global_move = in_score > gbest;
    move_dist   = ROW_W'(diag_dist(int'(row_n), int'(in_ridx)));
    n_best      = local_move ? in_rmax : best;
    n_brow      = local_move ? row_n : brow;
    n_bcol      = local_move ? in_ridx : bcol;
    n_off       = (local_move && move_dist > off) ? move_dist : off;
    n_gbest     = global_move ? in_score : gbest;
    n_grow      = global_move ? row_n : grow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row <= '0; best <= '0; brow <= '0; bcol <= '0; off <= '0;
      gbest <= '0; grow <= '0; qlen_r <= '0;
      res_valid <= 1'b0;
      res_local <= '0; res_local_row <= '0; res_local_col <= '0;
      res_global <= '0; res_global_row <= '0; res_max_off <= '0;
    end else begin
      res_valid <= 1'b0;
      if (start) begin
        row    <= '0;
        best   <= seed;
        brow   <= '0;
        bcol   <= '0;
        off    <= '0;
        gbest  <= score_t'(floor_sub(int'(seed), int'(qlen) * int'(gap)));
        grow   <= '0;
        qlen_r <= qlen;
      end else if (in_valid) begin
        row   <= row_n;
        best  <= n_best;
        brow  <= n_brow;
        bcol  <= n_bcol;
        off   <= n_off;
        gbest <= n_gbest;
        grow  <= n_grow;
        if (in_last) begin
          res_valid      <= 1'b1;
          res_local      <= n_best;
          res_local_row  <= n_brow;
          res_local_col  <= n_bcol;
          res_global     <= n_gbest;
          res_global_row <= n_grow;
          res_max_off    <= n_off;
        end
      end
    end
  end

  // R8: a result lasts one cycle
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R5: the global best is a cell of the matrix, so it cannot beat the local best
  assert_local_ge_global_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_local >= res_global);
  // R4: within a job the local best never falls
  assert_best_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !start |=> best >= $past(best));
  // R7: the reported column never lies past the exit point
  assert_col_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_local_col <= qlen_r);
endmodule

// File: rtl/seed_ext_array.sv
module seed_ext_array
  import seed_ext_pkg::*;
#(
  parameter int NPE   = 131,
  parameter int SYM_W = 2,
  parameter int PEN_W = 8,
  parameter int ROW_W = 16,
  localparam int IDX_W = $clog2(NPE + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 q_we,
  input  logic [IDX_W-1:0]     q_addr,
  input  logic [SYM_W-1:0]     q_sym,
  input  logic                 ext_start,
  input  logic [IDX_W-1:0]     ext_qlen,
  input  logic [SCORE_W-2:0]   ext_seed,
  input  logic [PEN_W-1:0]     cfg_match,
  input  logic [PEN_W-1:0]     cfg_mismatch,
  input  logic [PEN_W-1:0]     cfg_gap,
  input  logic                 ref_valid,
  input  logic [SYM_W-1:0]     ref_sym,
  input  logic                 ref_last,
  output logic                 res_valid,
  output logic [SCORE_W-1:0]   res_local,
  output logic [ROW_W-1:0]     res_local_row,
  output logic [IDX_W-1:0]     res_local_col,
  output logic [SCORE_W-1:0]   res_global,
  output logic [ROW_W-1:0]     res_global_row,
  output logic [ROW_W-1:0]     res_max_off
);
  logic [PEN_W-1:0] ma_r, mm_r, gap_r;
  logic [IDX_W-1:0] qlen_r;
  score_t           seed_w;

  assign seed_w = score_t'(ext_seed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ma_r <= '0; mm_r <= '0; gap_r <= '0; qlen_r <= '0;
    end else if (ext_start) begin
      ma_r   <= cfg_match;
      mm_r   <= cfg_mismatch;
      gap_r  <= cfg_gap;
      qlen_r <= ext_qlen;
    end
  end

  // link k is the input of the element at column k+1; link 0 leaves the head
  logic             lk_valid [0:NPE];
  logic             lk_first [0:NPE];
  logic             lk_last  [0:NPE];
  logic [SYM_W-1:0] lk_sym   [0:NPE];
  score_t           lk_score [0:NPE];
  score_t           lk_bnd   [0:NPE];
  score_t           lk_rmax  [0:NPE];
  logic [IDX_W-1:0] lk_ridx  [0:NPE];

  assign lk_rmax[0] = '0;
  assign lk_ridx[0] = '0;

  seed_ext_head #(.SYM_W(SYM_W), .PEN_W(PEN_W)) u_head (
    .clk(clk), .rst_n(rst_n), .start(ext_start), .seed(seed_w), .gap(gap_r),
    .in_valid(ref_valid), .in_sym(ref_sym), .in_last(ref_last),
    .out_valid(lk_valid[0]), .out_first(lk_first[0]), .out_last(lk_last[0]),
    .out_sym(lk_sym[0]), .out_score(lk_score[0]), .out_bnd(lk_bnd[0])
  );

  for (genvar k = 0; k < NPE; k++) begin : g_pe
    seed_ext_pe #(.SYM_W(SYM_W), .PEN_W(PEN_W), .IDX_W(IDX_W), .COL(k + 1)) u_pe (
      .clk(clk), .rst_n(rst_n), .q_we(q_we), .q_addr(q_addr), .q_sym(q_sym),
      .ma(ma_r), .mm(mm_r), .gap(gap_r),
      .in_valid(lk_valid[k]), .in_first(lk_first[k]), .in_last(lk_last[k]),
      .in_sym(lk_sym[k]), .in_score(lk_score[k]), .in_bnd(lk_bnd[k]),
      .in_rmax(lk_rmax[k]), .in_ridx(lk_ridx[k]),
      .out_valid(lk_valid[k+1]), .out_first(lk_first[k+1]), .out_last(lk_last[k+1]),
      .out_sym(lk_sym[k+1]), .out_score(lk_score[k+1]), .out_bnd(lk_bnd[k+1]),
      .out_rmax(lk_rmax[k+1]), .out_ridx(lk_ridx[k+1])
    );
  end

  // exit point: output of the element at column qlen
  logic             x_valid;
  logic             x_last;
  score_t           x_score;
  score_t           x_rmax;
  logic [IDX_W-1:0] x_ridx;

  always_comb begin
    x_valid = 1'b0;
    x_last  = 1'b0;
    x_score = '0;
    x_rmax  = '0;
    x_ridx  = '0;
    for (int k = 1; k <= NPE; k++) begin
      if (qlen_r == IDX_W'(k)) begin
        x_valid = lk_valid[k];
        x_last  = lk_last[k];
        x_score = lk_score[k];
        x_rmax  = lk_rmax[k];
        x_ridx  = lk_ridx[k];
      end
    end
  end

  seed_ext_tail #(.PEN_W(PEN_W), .IDX_W(IDX_W), .ROW_W(ROW_W)) u_tail (
    .clk(clk), .rst_n(rst_n), .start(ext_start), .seed(seed_w),
    .qlen(ext_qlen), .gap(cfg_gap),
    .in_valid(x_valid), .in_last(x_last), .in_score(x_score),
    .in_rmax(x_rmax), .in_ridx(x_ridx),
    .res_valid(res_valid), .res_local(res_local), .res_local_row(res_local_row),
    .res_local_col(res_local_col), .res_global(res_global),
    .res_global_row(res_global_row), .res_max_off(res_max_off)
  );

  // R1: nothing is reported before a reference symbol has been accepted
  assert_quiet_until_ref_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(x_valid));
endmodule

// File: tb/test_seed_ext_array.sv
module test_seed_ext_array;
  localparam int CLK_P = 10;
  localparam int NPE   = 131;
  localparam int MAXR  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q_we = 1'b0;
  logic [7:0] q_addr = '0;
  logic [1:0] q_sym = '0;
  logic ext_start = 1'b0;
  logic [7:0] ext_qlen = '0;
  logic [14:0] ext_seed = '0;
  logic [7:0] cfg_match = '0, cfg_mismatch = '0, cfg_gap = '0;
  logic ref_valid = 1'b0;
  logic [1:0] ref_sym = '0;
  logic ref_last = 1'b0;
  logic res_valid;
  logic [15:0] res_local, res_local_row, res_global, res_global_row, res_max_off;
  logic [7:0] res_local_col;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int q_mem [0:NPE-1];
  int r_mem [0:MAXR-1];

  always #(CLK_P/2) clk = ~clk;

  seed_ext_array i_seed_ext_array (
    .clk(clk), .rst_n(rst_n), .q_we(q_we), .q_addr(q_addr), .q_sym(q_sym),
    .ext_start(ext_start), .ext_qlen(ext_qlen), .ext_seed(ext_seed),
    .cfg_match(cfg_match), .cfg_mismatch(cfg_mismatch), .cfg_gap(cfg_gap),
    .ref_valid(ref_valid), .ref_sym(ref_sym), .ref_last(ref_last),
    .res_valid(res_valid), .res_local(res_local), .res_local_row(res_local_row),
    .res_local_col(res_local_col), .res_global(res_global),
    .res_global_row(res_global_row), .res_max_off(res_max_off)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int fl0(input int v);
    return v < 0 ? 0 : v;
  endfunction

  // reference model of the extension matrix, rows scanned in order
  task automatic model(input int n, input int m, input int s, input int ma,
                       input int mm, input int g, output int e_loc, output int e_lr,
                       output int e_lc, output int e_glo, output int e_gr,
                       output int e_off);
    int prv [0:NPE];
    int cur [0:NPE];
    e_loc = s; e_lr = 0; e_lc = 0; e_off = 0;
    e_glo = fl0(s - n * g); e_gr = 0;
    for (int c = 0; c <= n; c++) prv[c] = fl0(s - c * g);
    for (int i = 1; i <= m; i++) begin
      int rm;
      int rc;
      rm = 0; rc = 0;
      cur[0] = fl0(s - i * g);
      for (int c = 1; c <= n; c++) begin
        int h;
        int d;
        d = prv[c-1] + ((q_mem[c-1] == r_mem[i-1]) ? ma : -mm);
        h = 0;
        if (d > h) h = d;
        if (prv[c] - g > h) h = prv[c] - g;
        if (cur[c-1] - g > h) h = cur[c-1] - g;
        if (h > 32767) h = 32767;
        cur[c] = h;
        if (h > rm) begin rm = h; rc = c; end
      end
      if (rm > e_loc) begin
        int dd;
        e_loc = rm; e_lr = i; e_lc = rc;
        dd = (i > rc) ? i - rc : rc - i;
        if (dd > e_off) e_off = dd;
      end
      if (cur[n] > e_glo) begin e_glo = cur[n]; e_gr = i; end
      for (int c = 0; c <= n; c++) prv[c] = cur[c];
    end
  endtask

  task automatic run_ext(input string req, input int n, input int m, input int s,
                         input int ma, input int mm, input int g, input bit gaps);
    int e_loc, e_lr, e_lc, e_glo, e_gr, e_off;
    int cnt;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      q_we = 1'b1; q_addr = 8'(k); q_sym = 2'(q_mem[k]);
    end
    @(negedge clk);
    q_we = 1'b0;
    ext_start = 1'b1; ext_qlen = 8'(n); ext_seed = 15'(s);
    cfg_match = 8'(ma); cfg_mismatch = 8'(mm); cfg_gap = 8'(g);
    @(negedge clk);
    ext_start = 1'b0;
    for (int i = 0; i < m; i++) begin
      if (gaps) repeat ($urandom_range(0, 3)) @(negedge clk);
      ref_valid = 1'b1; ref_sym = 2'(r_mem[i]); ref_last = (i == m - 1);
      @(negedge clk);
      ref_valid = 1'b0; ref_last = 1'b0;
    end
    cnt = 0;
    while (!res_valid && cnt < 400) begin
      @(negedge clk);
      cnt++;
    end
    model(n, m, s, ma, mm, g, e_loc, e_lr, e_lc, e_glo, e_gr, e_off);
    chk("R8", {req, " latency"}, cnt, n + 1);
    chk("R2", {req, " local score"}, int'(res_local), e_loc);
    chk("R4", {req, " local row"}, int'(res_local_row), e_lr);
    chk("R4", {req, " local col"}, int'(res_local_col), e_lc);
    chk("R5", {req, " global score"}, int'(res_global), e_glo);
    chk("R5", {req, " global row"}, int'(res_global_row), e_gr);
    chk("R6", {req, " max offset"}, int'(res_max_off), e_off);
    @(negedge clk);
    chk("R8", {req, " pulse width"}, int'(res_valid), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet after reset
    chk("R1", "reset res_valid", int'(res_valid), 0);
    repeat (5) @(negedge clk);
    chk("R1", "idle res_valid", int'(res_valid), 0);

    // R4 R5: reference equals query, best lands in the last column on the last row
    for (int k = 0; k < 8; k++) begin q_mem[k] = k % 4; r_mem[k] = k % 4; end
    run_ext("R4 diagonal", 8, 8, 20, 2, 1, 1, 0);

    // R3: all mismatches, seed stays best at the origin
    for (int k = 0; k < 6; k++) begin q_mem[k] = 0; r_mem[k] = 1; end
    run_ext("R3 mismatch", 6, 6, 3, 2, 1, 1, 0);
    chk("R3", "origin row", int'(res_local_row), 0);
    // R3: zero seed, boundary clamped
    for (int k = 0; k < 5; k++) r_mem[k] = 0;
    run_ext("R3 zero seed", 6, 5, 0, 2, 1, 1, 0);

    // R7: shortest and longest query
    q_mem[0] = 2; r_mem[0] = 2; r_mem[1] = 3; r_mem[2] = 2;
    run_ext("R7 len1", 1, 3, 10, 2, 1, 1, 0);
    for (int k = 0; k < NPE; k++) q_mem[k] = $urandom_range(0, 3);
    for (int k = 0; k < 40; k++) r_mem[k] = q_mem[k + 5];
    run_ext("R7 len131", NPE, 40, 30, 2, 1, 1, 0);

    // R10: saturation at the score limit
    for (int k = 0; k < 10; k++) begin q_mem[k] = 1; r_mem[k] = 1; end
    run_ext("R10 saturate", 10, 10, 32767, 2, 1, 1, 0);
    run_ext("R10 near limit", 10, 10, 32760, 2, 1, 1, 0);

    // R9: same job with and without idle cycles
    for (int k = 0; k < 20; k++) q_mem[k] = $urandom_range(0, 3);
    for (int k = 0; k < 30; k++) r_mem[k] = $urandom_range(0, 3);
    run_ext("R9 dense", 20, 30, 25, 2, 1, 1, 0);
    run_ext("R9 gappy", 20, 30, 25, 2, 1, 1, 1);

    // random jobs, R2 recurrence under varied parameters
    for (int t = 0; t < 40; t++) begin
      int n, m, s, ma, mm, g;
      n = $urandom_range(1, NPE);
      m = $urandom_range(1, MAXR);
      s = $urandom_range(0, 60);
      if (t < 20) begin ma = 2; mm = 1; g = 1; end
      else begin ma = $urandom_range(1, 4); mm = $urandom_range(0, 3); g = $urandom_range(1, 3); end
      for (int k = 0; k < n; k++) q_mem[k] = $urandom_range(0, 3);
      for (int k = 0; k < m; k++)
        r_mem[k] = ($urandom_range(0, 3) != 0 && k < n) ? q_mem[k] : $urandom_range(0, 3);
      run_ext("R2 random", n, m, s, ma, mm, g, (t % 3) == 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule